// File: doc/BRIEF.md
# Fail-Safe Clock Monitor with Backup Switchover

This block supervises a fast primary clock using a slower internal oscillator that is always running. Every `SAMPLE_DIV` internal-oscillator cycles it sends a probe into the primary domain and expects the primary clock to echo it back before the next probe is due. An unanswered probe means the primary clock has stopped. When that happens the block moves the device clock onto the internal oscillator, sets a sticky failure flag, and can raise an interrupt.

After reset or a wake-up pulse, the block keeps the device on the internal oscillator until the primary source is ready. A direct external clock is ready at once. A crystal source is ready only when the start-up timer reports done, and in PLL mode also when the PLL reports lock. No probe is judged during this hold-off, so a crystal that never starts is not flagged. Software can poll `pri_active` and apply its own time limit. After a failure the block never returns to the primary clock by itself. Software first clears the flag and then issues a reselect strobe. When a power-managed mode turns the primary clock off on purpose, that mode is signalled on `pri_gated` and the monitor stops judging probes.

The clock switchover uses a handshake. The enable of the clock in use drops before the enable of the incoming clock rises. The primary-side enable is also cleared asynchronously when a failure is declared, because a dead clock cannot clock its own enable low.

Top module: `clk_failsafe_mon`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `fail_flag`, `fail_irq` and `pri_active` are 0, and `dev_clk` is driven from `clk_int`.
- R2: `osc_mode` encodes 0 = direct external clock, 1 = low-speed crystal, 2 = high-speed crystal, 3 = high-speed crystal with PLL. The primary clock is ready in mode 0 at once, in modes 1 and 2 when `tmr_done` = 1, and in mode 3 when `tmr_done` = 1 and `pll_lock` = 1. Until it is ready, `pri_active` stays 0 and `dev_clk` runs from `clk_int`. Once it is ready, `pri_active` becomes 1 within 15 `clk_int` cycles and `dev_clk` runs from `clk_pri`.
- R3: During the start-up hold-off, a primary clock that does not toggle never sets `fail_flag`.
- R4: A primary clock that keeps running at least 2.5 times faster than `clk_int` never sets `fail_flag`.
- R5: If the primary clock stops while it is selected and `pri_gated` = 0, `fail_flag` rises within 2*`SAMPLE_DIV`+6 `clk_int` cycles. `pri_active` is then 0 and `dev_clk` runs from `clk_int`.
- R6: `fail_irq` equals `fail_flag` AND `irq_en`, delayed by one `clk_int` cycle.
- R7: `fail_flag` stays at 1 until a `flag_clr` strobe clears it. The device stays on `clk_int` after the flag is cleared. A `reselect` strobe has no effect while the flag is 1.
- R8: A `reselect` strobe with `fail_flag` = 0 after a failure starts the start-up hold-off again. The device then returns to the primary clock under the readiness rule of R2.
- R9: While `pri_gated` = 1 the primary clock may stop without setting `fail_flag`. When it restarts and `pri_gated` returns to 0, no failure is reported.
- R10: A `wake` pulse while the primary clock is in use starts the start-up hold-off again. In a crystal mode with `tmr_done` = 0, `pri_active` falls to 0 and the device runs from `clk_int` until the timer is done.
- R11: The two clock enables feeding `dev_clk` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock; clocks the control logic and is the sample and backup clock |
| rst | input | 1 | Synchronous active-high reset, in the `clk_int` domain |
| clk_pri | input | 1 | Primary clock being monitored |
| osc_mode | input | 2 | Primary source kind (encoding in R2) |
| tmr_done | input | 1 | Oscillator start-up timer has expired |
| pll_lock | input | 1 | PLL lock timer has expired (used in mode 3 only) |
| pri_gated | input | 1 | Power-managed mode has turned the primary clock off on purpose |
| wake | input | 1 | One-cycle pulse: wake-up from sleep |
| irq_en | input | 1 | Failure interrupt enable |
| flag_clr | input | 1 | One-cycle strobe that clears the failure flag |
| reselect | input | 1 | One-cycle strobe that requests a return to the primary clock |
| dev_clk | output | 1 | Selected device clock |
| fail_flag | output | 1 | Sticky clock failure flag |
| fail_irq | output | 1 | Failure interrupt request |
| pri_active | output | 1 | Start-up status: primary clock is ready and is driving `dev_clk` |

## Verification
Timing is counted in `clk_int` cycles. `fail_irq` follows `fail_flag` by exactly one cycle, so it is sampled on the next falling edge. `pri_active` passes through synchronizers in both clock domains and then a register, so the bench waits a fixed 20 cycles before reading it. A failure may be reported at any point in a window after the primary clock stops, so the bench polls `fail_flag` on each falling edge and compares the number of cycles against the R5 bound. The source of `dev_clk` is found by counting its rising edges over 40 `clk_int` cycles: about 40 edges means the internal oscillator, about 100 means the 8 ns primary clock. The start-up rule is swept over every mode and every combination of timer and lock.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT    = 2'd0,
    MODE_XTAL_LOW  = 2'd1,
    MODE_XTAL_HIGH = 2'd2,
    MODE_XTAL_PLL  = 2'd3
  } osc_mode_e;

  typedef enum logic [1:0] {
    SW_HOLD = 2'd0,
    SW_PRI  = 2'd1,
    SW_FAIL = 2'd2
  } sw_state_e;

  // Primary source readiness by kind: direct clocks need no start-up wait.
  function automatic logic primary_ready(input logic [1:0] mode,
                                         input logic tmr, input logic lock);
    case (mode)
      MODE_DIRECT:   primary_ready = 1'b1;
      MODE_XTAL_PLL: primary_ready = tmr & lock;
      default:       primary_ready = tmr;
    endcase
  endfunction

endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfm_detect.sv
module cfm_detect #(
  parameter int SAMPLE_DIV  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_int,
  input  logic rst,
  input  logic clk_pri,
  input  logic rst_pri,
  input  logic armed,
  output logic fail_det
);
  localparam int CNT_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic probe, primed, echo, probe_p, echo_s;
  logic tick, pending;

  // Primary side: return the probe level once the primary clock has seen it.
  cfm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_probe_sync (
    .clk(clk_pri), .rst(rst_pri), .d(probe), .q(probe_p));

  always_ff @(posedge clk_pri) begin
    if (rst_pri) echo <= 1'b0;
    else         echo <= probe_p;
  end

  cfm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_echo_sync (
    .clk(clk_int), .rst(rst), .d(echo), .q(echo_s));

  assign tick    = (cnt == CNT_LAST);
  assign pending = probe ^ echo_s;   // monitor latch: set by probe, cleared by echo

  always_ff @(posedge clk_int) begin
    if (rst) begin
      cnt      <= '0;
      probe    <= 1'b0;
      primed   <= 1'b0;
      fail_det <= 1'b0;
    end else begin
      cnt      <= tick ? '0 : cnt + 1'b1;
      fail_det <= 1'b0;
      if (!armed) begin
        primed <= 1'b0;
      end else if (tick) begin
        if (!pending) begin
          probe  <= ~probe;
          primed <= 1'b1;
        end else if (primed) begin
          fail_det <= 1'b1;
        end
      end
    end
  end

  // R5: a new probe is launched only after the previous one was answered
  p_probe_after_echo_r5: assert property (@(posedge clk_int) disable iff (rst)
    (probe != $past(probe)) |-> $past(!pending && armed));

  // R3 / R9: no failure is reported unless the monitor was armed and primed
  p_fail_only_armed_r3: assert property (@(posedge clk_int) disable iff (rst)
    fail_det |-> $past(armed && primed));
endmodule

// File: rtl/cfm_switch.sv
module cfm_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_int,
  input  logic rst,
  input  logic clk_pri,
  input  logic rst_pri,
  input  logic sel_pri,
  input  logic force_int,
  output logic dev_clk,
  output logic pri_on
);
  logic en_int, en_pri, en_int_p, sel_p;

  // Backup side: enable rises only after the primary enable is seen low.
  cfm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_enpri_sync (
    .clk(clk_int), .rst(rst), .d(en_pri), .q(pri_on));

  always_ff @(negedge clk_int) begin
    if (rst) en_int <= 1'b1;
    else     en_int <= !sel_pri && !pri_on;
  end

  // Primary side: enable rises only after the backup enable is seen low.
  cfm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sel_sync (
    .clk(clk_pri), .rst(rst_pri), .d(sel_pri), .q(sel_p));
  cfm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_enint_sync (
    .clk(clk_pri), .rst(rst_pri), .d(en_int), .q(en_int_p));

  // Asynchronous clear: a stopped primary clock cannot drop its own enable.
  always_ff @(negedge clk_pri or posedge force_int) begin
    if (force_int)    en_pri <= 1'b0;
    else if (rst_pri) en_pri <= 1'b0;
    else              en_pri <= sel_p && !en_int_p;
  end

  assign dev_clk = (clk_pri & en_pri) | (clk_int & en_int);

  // R11: break-before-make between the two enables
  p_one_source_r11: assert property (@(posedge clk_int) disable iff (rst)
    !(en_int && en_pri));
endmodule

// File: rtl/clk_failsafe_mon.sv
module clk_failsafe_mon
  import cfm_pkg::*;
#(
  parameter int SAMPLE_DIV  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_int,
  input  logic       rst,
  input  logic       clk_pri,
  input  logic [1:0] osc_mode,
  input  logic       tmr_done,
  input  logic       pll_lock,
  input  logic       pri_gated,
  input  logic       wake,
  input  logic       irq_en,
  input  logic       flag_clr,
  input  logic       reselect,
  output logic       dev_clk,
  output logic       fail_flag,
  output logic       fail_irq,
  output logic       pri_active
);
  sw_state_e state, state_nx;
  logic rst_pri, det_fail, pri_on, armed, ready;
  logic sel_q, force_q;

  cfm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_pri (
    .clk(clk_pri), .rst(1'b0), .d(rst), .q(rst_pri));

  assign ready = primary_ready(osc_mode, tmr_done, pll_lock);
  assign armed = (state == SW_PRI) && !pri_gated;

  cfm_detect #(.SAMPLE_DIV(SAMPLE_DIV), .SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk_int(clk_int), .rst(rst), .clk_pri(clk_pri), .rst_pri(rst_pri),
    .armed(armed), .fail_det(det_fail));

  cfm_switch #(.SYNC_STAGES(SYNC_STAGES)) u_switch (
    .clk_int(clk_int), .rst(rst), .clk_pri(clk_pri), .rst_pri(rst_pri),
    .sel_pri(sel_q), .force_int(force_q), .dev_clk(dev_clk), .pri_on(pri_on));

  always_comb begin
    state_nx = state;
    case (state)
      SW_HOLD: if (ready && !wake) state_nx = SW_PRI;
      SW_PRI:  if (det_fail)       state_nx = SW_FAIL;
               else if (wake)      state_nx = SW_HOLD;
      SW_FAIL: if (reselect && !fail_flag) state_nx = SW_HOLD;
      default: state_nx = SW_HOLD;
    endcase
  end

  always_ff @(posedge clk_int) begin
    if (rst) begin
      state      <= SW_HOLD;
      sel_q      <= 1'b0;
      force_q    <= 1'b0;
      fail_flag  <= 1'b0;
      fail_irq   <= 1'b0;
      pri_active <= 1'b0;
    end else begin
      state      <= state_nx;
      sel_q      <= (state_nx == SW_PRI);
      force_q    <= (state_nx == SW_FAIL);
      if (det_fail)      fail_flag <= 1'b1;
      else if (flag_clr) fail_flag <= 1'b0;
      fail_irq   <= fail_flag && irq_en;
      pri_active <= (state == SW_PRI) && pri_on;
    end
  end

  // R2: the hold-off is left only when the selected source is ready
  p_hold_waits_r2: assert property (@(posedge clk_int) disable iff (rst)
    (state == SW_HOLD && !ready) |=> (state != SW_PRI));

  // R7: the failure state is left only through a reselect with the flag clear
  p_no_auto_return_r7: assert property (@(posedge clk_int) disable iff (rst)
    ($past(state == SW_FAIL) && state != SW_FAIL) |-> $past(reselect && !fail_flag));

  // R7: the flag holds without a clear strobe
  p_flag_sticky_r7: assert property (@(posedge clk_int) disable iff (rst)
    (fail_flag && !flag_clr) |=> fail_flag);

  // R5: on a failure the device is taken off the primary clock
  p_fail_leaves_pri_r5: assert property (@(posedge clk_int) disable iff (rst)
    $rose(fail_flag) |-> (state == SW_FAIL));
endmodule

// File: tb/clk_failsafe_mon_tb.sv
module clk_failsafe_mon_tb;
  localparam int SDIV = 16;

  logic clk_int = 1'b0, clk_pri = 1'b0, pri_run = 1'b1;
  logic rst = 1'b1;
  logic [1:0] osc_mode = 2'd0;
  logic tmr_done = 1'b0, pll_lock = 1'b0, pri_gated = 1'b0, wake = 1'b0;
  logic irq_en = 1'b0, flag_clr = 1'b0, reselect = 1'b0;
  logic dev_clk, fail_flag, fail_irq, pri_active;
  int checks = 0, errors = 0, dev_edges = 0, cyc = 0;

  clk_failsafe_mon #(.SAMPLE_DIV(SDIV), .SYNC_STAGES(2)) u_dut (
    .clk_int(clk_int), .rst(rst), .clk_pri(clk_pri), .osc_mode(osc_mode),
    .tmr_done(tmr_done), .pll_lock(pll_lock), .pri_gated(pri_gated),
    .wake(wake), .irq_en(irq_en), .flag_clr(flag_clr), .reselect(reselect),
    .dev_clk(dev_clk), .fail_flag(fail_flag), .fail_irq(fail_irq),
    .pri_active(pri_active));

  always #10 clk_int = ~clk_int;                 // 50 MHz
  initial forever #4 clk_pri = pri_run ? ~clk_pri : clk_pri;
  always @(posedge dev_clk) dev_edges++;

  always @(posedge clk_int) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_int);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(posedge clk_int); #1 sig = 1'b1;
    @(posedge clk_int); #1 sig = 1'b0;
  endtask

  // Rising edges of dev_clk over 40 clk_int cycles: ~40 on backup, ~100 on primary
  task automatic edges40(output int n);
    @(negedge clk_int);
    dev_edges = 0;
    repeat (40) @(negedge clk_int);
    n = dev_edges;
  endtask

  task automatic do_reset();
    pri_run = 1'b1;
    #1 rst = 1'b1;
    wait_cyc(10);
    rst = 1'b0;
  endtask

  initial begin
    int n, exp_rdy, waited;
    // R1: reset state
    do_reset();
    @(negedge clk_int);
    chk(!fail_flag && !fail_irq && !pri_active, "R1", {fail_flag, fail_irq, pri_active}, 0);

    // R2: sweep every mode against every timer/lock combination
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 4; c++) begin
        osc_mode = 2'(m); tmr_done = c[0]; pll_lock = c[1];
        do_reset();
        wait_cyc(20);
        exp_rdy = (m == 0) ? 1 : (m == 3) ? (c[0] & c[1]) : c[0];
        @(negedge clk_int);
        chk(pri_active == exp_rdy, "R2 ready", pri_active, exp_rdy);
      end
    end
    edges40(n);
    chk(n >= 95, "R2 primary drives dev_clk", n, 100);

    // R3: crystal never starts during hold-off
    osc_mode = 2'd1; tmr_done = 1'b0; pll_lock = 1'b0;
    do_reset();
    pri_run = 1'b0;
    wait_cyc(200);
    @(negedge clk_int);
    chk(!fail_flag, "R3 no flag in hold-off", fail_flag, 0);
    chk(!pri_active, "R3 pri_active low", pri_active, 0);
    edges40(n);
    chk(n >= 38 && n <= 42, "R3 backup drives dev_clk", n, 40);
    pri_run = 1'b1; tmr_done = 1'b1;
    wait_cyc(20);
    @(negedge clk_int);
    chk(pri_active, "R2 ready after timer", pri_active, 1);

    // R4: running primary gives no false failure
    wait_cyc(400);
    @(negedge clk_int);
    chk(!fail_flag, "R4 no false failure", fail_flag, 0);

    // R5/R6: primary stops with interrupt enabled
    irq_en = 1'b1;
    wait_cyc(3);
    pri_run = 1'b0;
    waited = 0;
    @(negedge clk_int);
    while (!fail_flag && waited < 80) begin
      @(negedge clk_int);
      waited++;
    end
    chk(fail_flag && waited <= 2*SDIV + 6, "R5 detection time", waited, 2*SDIV + 6);
    chk(!fail_irq, "R6 irq lags one cycle", fail_irq, 0);
    @(negedge clk_int);
    chk(fail_irq, "R6 irq follows flag", fail_irq, 1);
    wait_cyc(10);
    @(negedge clk_int);
    chk(!pri_active, "R5 off primary", pri_active, 0);
    edges40(n);
    chk(n >= 38 && n <= 42, "R5 backup drives dev_clk", n, 40);
    irq_en = 1'b0;
    @(negedge clk_int); @(negedge clk_int);
    chk(!fail_irq && fail_flag, "R6 irq masked", {fail_irq, fail_flag}, 1);

    // R7: sticky flag, reselect ignored while set, no automatic return
    pri_run = 1'b1;
    wait_cyc(100);
    @(negedge clk_int);
    chk(fail_flag && !pri_active, "R7 sticky, no auto return", {fail_flag, pri_active}, 2);
    pulse(reselect);
    wait_cyc(20);
    @(negedge clk_int);
    chk(fail_flag && !pri_active, "R7 reselect ignored with flag set", {fail_flag, pri_active}, 2);
    pulse(flag_clr);
    wait_cyc(30);
    @(negedge clk_int);
    chk(!fail_flag && !pri_active, "R7 clear keeps backup", {fail_flag, pri_active}, 0);

    // R8: reselect with flag clear returns through the hold-off
    tmr_done = 1'b0;
    pulse(reselect);
    wait_cyc(30);
    @(negedge clk_int);
    chk(!pri_active, "R8 reselect waits timer", pri_active, 0);
    tmr_done = 1'b1;
    wait_cyc(20);
    @(negedge clk_int);
    chk(pri_active, "R8 back on primary", pri_active, 1);
    edges40(n);
    chk(n >= 95, "R8 primary drives dev_clk", n, 100);

    // R9: intentional stop under a power-managed mode
    pri_gated = 1'b1;
    wait_cyc(2);
    pri_run = 1'b0;
    wait_cyc(200);
    @(negedge clk_int);
    chk(!fail_flag, "R9 gated stop not flagged", fail_flag, 0);
    pri_run = 1'b1;
    wait_cyc(10);
    pri_gated = 1'b0;
    wait_cyc(300);
    @(negedge clk_int);
    chk(!fail_flag && pri_active, "R9 resume without flag", {fail_flag, pri_active}, 1);

    // R10: wake restarts the hold-off
    tmr_done = 1'b0;
    pulse(wake);
    wait_cyc(20);
    @(negedge clk_int);
    chk(!pri_active && !fail_flag, "R10 wake holds backup", {fail_flag, pri_active}, 0);
    edges40(n);
    chk(n >= 38 && n <= 42, "R10 backup drives dev_clk", n, 40);
    tmr_done = 1'b1;
    wait_cyc(20);
    @(negedge clk_int);
    chk(pri_active, "R10 primary after timer", pri_active, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule